// File: doc/BRIEF.md
# Parallel Converter Sampling Sequencer

This block sits on the host side of a small external analog-to-digital converter. The converter has an 8-bit parallel data bus, an active-low start strobe and an active-low done flag. The block starts a conversion at a fixed cadence, counted in clock cycles. It waits for the converter to report completion and then runs one read cycle, during which it captures the byte. Each byte leaves as a one-cycle beat on a valid/ready stream, together with a tag giving the channel it was taken from.

The start strobe is kept short, so the converter goes back to sleep after every conversion, and between samples the part draws almost nothing. Channel selection needs no configuration write. During each read strobe, the address lines already carry the channel for the following conversion. The sequence walks through the configured number of inputs and wraps back to the first.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the start, select and read strobes are high. Valid, overrun and the drop count are zero. The channel index is 0, so the address lines show 1 (modulo the channel count).
- R2: Each start pulse is low for exactly min(CONV_PULSE_CYC, PWRUP_CYC) cycles, and never less than one. When no start is skipped, successive falling edges are `period` cycles apart. When starts are skipped, the spacing is a whole multiple of `period`.
- R3: Once the start strobe is high again, the block waits for the done flag. Select and read go low together in the cycle after the done flag is sampled low. They stay low for `rd_len` cycles, a value of 0 being taken as 1.
- R4: The data bus is captured in the last cycle of the read window. `m_valid` is high for exactly the one cycle in which the read strobe has just returned high, and `m_data` then carries the captured byte.
- R5: The 3-bit tag `m_chan` names the channel that was converted. The tags run 0, 1, …, NUM_CH-1 and then wrap to 0, advancing once per read.
- R6: When the read strobe falls, the address lines show (tag of the sample being read + 1) mod NUM_CH. They do not change while the read strobe is low.
- R7: A beat offered while `m_ready` is low is lost, and `drop_count` rises by one in the next cycle. In every other cycle `drop_count` holds its value.
- R8: A sample-period tick that arrives while a sample is still in progress is not started. Instead `overrun` is high for one cycle.
- R9: Chip-select and read always have the same level. The start strobe is never low while the read strobe is low.
- R10: Lowering `enable` lets the sample in progress complete and be delivered, but no further start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Allows new conversions to start |
| period | input | PERIOD_W | Sample period in clock cycles |
| rd_len | input | RD_LEN_W | Read window length in cycles (0 acts as 1) |
| adc_convst_n | output | 1 | Conversion start strobe, active low |
| adc_eoc_n | input | 1 | Conversion done flag, active low, synchronous to clk |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_addr | output | ADDR_PW | Channel for the next conversion |
| adc_data | input | DATA_W | Converter data bus |
| m_valid | output | 1 | Sample beat valid |
| m_ready | input | 1 | Downstream can accept the beat |
| m_data | output | DATA_W | Sample value |
| m_chan | output | 3 | Channel tag of the sample |
| overrun | output | 1 | One-cycle flag for a skipped period tick |
| drop_count | output | CNT_W | Count of beats lost while not ready, wraps |

## Verification
The hardest condition to reach from the ports is a period tick that lands while a sample is still in progress. The bench gets there by shortening the period to 10 cycles while the converter model delays its done flag by 12 cycles, so every other tick arrives while the block is busy. The converter model in the bench latches the address at each read strobe. It derives the byte from that channel and a running count, so any mismatch between address, tag and data shows up on the stream. Backpressure is tested by holding `m_ready` low over several beats. Turning `enable` off just after a start pulse shows that the sample in progress still completes and that no new start follows.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int TAG_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_READ
    } seq_state_e;

endpackage

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);

    logic [PERIOD_W-1:0] cnt_d, cnt_q;

    assign tick = enable && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (!enable) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = (period == '0) ? '0 : period - 1'b1;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq #(
    parameter int NUM_CH  = 8,
    parameter int TAG_W   = 3,
    parameter int ADDR_PW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    output logic [TAG_W-1:0]   cur_chan,
    output logic [ADDR_PW-1:0] next_addr
);

    generate
        if (NUM_CH == 1) begin : g_single
            assign cur_chan  = '0;
            assign next_addr = '0;
        end else begin : g_multi
            localparam logic [TAG_W-1:0] LAST = TAG_W'(NUM_CH - 1);

            logic [TAG_W-1:0] chan_d, chan_q;
            logic [TAG_W-1:0] succ;

            assign succ = (chan_q == LAST) ? '0 : chan_q + 1'b1;

            always_comb begin
                chan_d = chan_q;
                if (advance) begin
                    chan_d = succ;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chan_q <= '0;
                end else begin
                    chan_q <= chan_d;
                end
            end

            assign cur_chan  = chan_q;
            assign next_addr = succ[ADDR_PW-1:0];
        end
    endgenerate

endmodule

// File: rtl/adc_stream_out.sv
module adc_stream_out #(
    parameter int DATA_W = 8,
    parameter int TAG_W  = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [TAG_W-1:0]  load_chan,
    input  logic              m_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic [TAG_W-1:0]  m_chan,
    output logic [CNT_W-1:0]  drop_count
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  chan;
        logic [CNT_W-1:0]  drops;
    } out_s;

    out_s o_d, o_q;

    always_comb begin
        o_d       = o_q;
        o_d.valid = load;
        if (load) begin
            o_d.data = load_data;
            o_d.chan = load_chan;
        end
        if (o_q.valid && !m_ready) begin
            o_d.drops = o_q.drops + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign m_valid    = o_q.valid;
    assign m_data     = o_q.data;
    assign m_chan     = o_q.chan;
    assign drop_count = o_q.drops;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH         = 8,
    parameter int PWRUP_CYC      = 100,
    parameter int CONV_PULSE_CYC = 50,
    parameter int PERIOD_W       = 16,
    parameter int RD_LEN_W       = 4,
    parameter int DATA_W         = 8,
    parameter int CNT_W          = 16,
    localparam int ADDR_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 0,
    localparam int ADDR_PW       = (ADDR_W > 0) ? ADDR_W : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    input  logic [RD_LEN_W-1:0] rd_len,
    output logic                adc_convst_n,
    input  logic                adc_eoc_n,
    output logic                adc_cs_n,
    output logic                adc_rd_n,
    output logic [ADDR_PW-1:0]  adc_addr,
    input  logic [DATA_W-1:0]   adc_data,
    output logic                m_valid,
    input  logic                m_ready,
    output logic [DATA_W-1:0]   m_data,
    output logic [TAG_W-1:0]    m_chan,
    output logic                overrun,
    output logic [CNT_W-1:0]    drop_count
);

    // Start pulse is clamped to the wake-up time so the part sleeps again.
    localparam int PULSE_RAW = (CONV_PULSE_CYC < PWRUP_CYC) ? CONV_PULSE_CYC : PWRUP_CYC;
    localparam int PULSE_EFF = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
    localparam int PC_W      = $clog2(PULSE_EFF + 1);

    typedef struct packed {
        seq_state_e          state;
        logic [PC_W-1:0]     pcnt;
        logic [RD_LEN_W-1:0] rcnt;
        logic                convst_n;
        logic                cs_n;
        logic                rd_n;
        logic                overrun;
    } ctrl_s;

    ctrl_s c_d, c_q;

    logic             tick;
    logic             read_done;
    logic [TAG_W-1:0] cur_chan;

    adc_rate_timer #(
        .PERIOD_W (PERIOD_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .period (period),
        .tick   (tick)
    );

    adc_chan_seq #(
        .NUM_CH  (NUM_CH),
        .TAG_W   (TAG_W),
        .ADDR_PW (ADDR_PW)
    ) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (read_done),
        .cur_chan  (cur_chan),
        .next_addr (adc_addr)
    );

    adc_stream_out #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .CNT_W  (CNT_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (read_done),
        .load_data  (adc_data),
        .load_chan  (cur_chan),
        .m_ready    (m_ready),
        .m_valid    (m_valid),
        .m_data     (m_data),
        .m_chan     (m_chan),
        .drop_count (drop_count)
    );

    always_comb begin
        c_d         = c_q;
        c_d.overrun = tick && (c_q.state != ST_IDLE);
        read_done   = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (tick) begin
                    c_d.state    = ST_CONV;
                    c_d.convst_n = 1'b0;
                    c_d.pcnt     = PC_W'(PULSE_EFF - 1);
                end
            end
            ST_CONV: begin
                if (c_q.pcnt == '0) begin
                    c_d.convst_n = 1'b1;
                    c_d.state    = ST_WAIT;
                end else begin
                    c_d.pcnt = c_q.pcnt - 1'b1;
                end
            end
            ST_WAIT: begin
                if (!adc_eoc_n) begin
                    c_d.state = ST_READ;
                    c_d.cs_n  = 1'b0;
                    c_d.rd_n  = 1'b0;
                    c_d.rcnt  = (rd_len == '0) ? '0 : rd_len - 1'b1;
                end
            end
            ST_READ: begin
                if (c_q.rcnt == '0) begin
                    read_done = 1'b1;
                    c_d.cs_n  = 1'b1;
                    c_d.rd_n  = 1'b1;
                    c_d.state = ST_IDLE;
                end else begin
                    c_d.rcnt = c_q.rcnt - 1'b1;
                end
            end
            default: begin
                c_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, pcnt: '0, rcnt: '0, convst_n: 1'b1,
                     cs_n: 1'b1, rd_n: 1'b1, overrun: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign adc_convst_n = c_q.convst_n;
    assign adc_cs_n     = c_q.cs_n;
    assign adc_rd_n     = c_q.rd_n;
    assign overrun      = c_q.overrun;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int NUM_CH    = 8,
    parameter int PULSE_LEN = 1,
    parameter int ADDR_PW   = 3,
    parameter int CNT_W     = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               convst_n,
    input logic               cs_n,
    input logic               rd_n,
    input logic               eoc_n,
    input logic [ADDR_PW-1:0] addr,
    input logic               m_valid,
    input logic               m_ready,
    input logic [2:0]         m_chan,
    input logic [CNT_W-1:0]   drop_count
);

    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!convst_n) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    a_r2_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
        !convst_n |-> (32'(low_cnt) < PULSE_LEN));

    a_r3_read_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !$past(eoc_n));

    a_r4_valid_on_read_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> m_valid);

    a_r4_valid_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> $rose(rd_n));

    a_r5_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (32'(m_chan) < NUM_CH));

    a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !$past(rd_n)) |-> $stable(addr));

    a_r7_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(m_valid && !m_ready) |-> (drop_count == $past(drop_count) + CNT_W'(1)));

    a_r7_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(m_valid && !m_ready) |-> $stable(drop_count));

    a_r9_strobes_paired: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n == rd_n);

    a_r9_no_start_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> convst_n);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .NUM_CH    (NUM_CH),
    .PULSE_LEN (PULSE_EFF),
    .ADDR_PW   (ADDR_PW),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .convst_n   (adc_convst_n),
    .cs_n       (adc_cs_n),
    .rd_n       (adc_rd_n),
    .eoc_n      (adc_eoc_n),
    .addr       (adc_addr),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_chan     (m_chan),
    .drop_count (drop_count)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 8;
    localparam int PWRUP      = 4;
    localparam int PULSE_REQ  = 6;
    localparam int PULSE_EXP  = 4;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] period = 8'd30;
    logic [2:0] rd_len = 3'd3;
    logic       m_ready = 1'b1;
    logic       eoc_drv = 1'b1;
    logic [7:0] cur_val = 8'h00;

    wire        convst_n, cs_n, rd_n, m_valid, overrun;
    wire [2:0]  addr, m_chan;
    wire [7:0]  m_data, drop_count;
    wire [7:0]  adc_data = (!cs_n && !rd_n) ? cur_val : 8'hzz;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int eoc_delay = 8;
    int n_valid = 0;
    int falls = 0;
    int ovr_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_seq_ctrl #(
        .NUM_CH         (NUM_CH),
        .PWRUP_CYC      (PWRUP),
        .CONV_PULSE_CYC (PULSE_REQ),
        .PERIOD_W       (8),
        .RD_LEN_W       (3),
        .DATA_W         (8),
        .CNT_W          (8)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .period       (period),
        .rd_len       (rd_len),
        .adc_convst_n (convst_n),
        .adc_eoc_n    (eoc_drv),
        .adc_cs_n     (cs_n),
        .adc_rd_n     (rd_n),
        .adc_addr     (addr),
        .adc_data     (adc_data),
        .m_valid      (m_valid),
        .m_ready      (m_ready),
        .m_data       (m_data),
        .m_chan       (m_chan),
        .overrun      (overrun),
        .drop_count   (drop_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Converter model and reference monitor, sampled on the falling edge.
    initial begin : monitor
        logic       prev_convst = 1'b1;
        logic       prev_rd = 1'b1;
        logic       reset_checked = 1'b0;
        logic       waiting = 1'b0;
        logic [2:0] mux_ch = 3'd0;
        logic [2:0] addr_hold = 3'd0;
        logic [10:0] exp_q[$];
        logic [10:0] ent;
        int low_len = 0;
        int rd_obs = 0;
        int since = -1;
        int seq = 0;
        int tag_seq = 0;
        int last_fall = -1;
        int exp_drop = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                checks++;
                fails++;
                $display("FAIL watchdog: got %0d expected %0d", cyc, WATCHDOG);
                summary();
            end
            if (rst_n) begin
                if (!reset_checked) begin
                    reset_checked = 1'b1;
                    check("R1 convst", convst_n, 1);
                    check("R1 cs", cs_n, 1);
                    check("R1 rd", rd_n, 1);
                    check("R1 valid", m_valid, 0);
                    check("R1 overrun", overrun, 0);
                    check("R1 drops", drop_count, 0);
                    check("R1 addr", addr, 1);
                end
                check("R9 paired", cs_n, rd_n);
                if (!rd_n) check("R9 start in read", convst_n, 1);
                check("R7 drops", drop_count, exp_drop);
                if (m_valid && !m_ready) exp_drop = (exp_drop + 1) % 256;
                if (overrun) ovr_cnt++;
                if (!enable) last_fall = -1;

                if (prev_convst && !convst_n) begin
                    falls++;
                    if (last_fall >= 0) check("R2 spacing", (cyc - last_fall) % int'(period), 0);
                    last_fall = cyc;
                    low_len = 1;
                    cur_val = {mux_ch, 5'(seq)};
                    exp_q.push_back({mux_ch, cur_val});
                    seq++;
                    since = 0;
                end else if (!convst_n) begin
                    low_len++;
                end else if (!prev_convst) begin
                    check("R2 pulse length", low_len, PULSE_EXP);
                    waiting = 1'b1;
                end

                if (waiting && !eoc_drv) check("R3 read start", rd_n, 0);
                if (prev_rd && !rd_n) begin
                    waiting = 1'b0;
                    rd_obs = 1;
                    if (exp_q.size() > 0) check("R6 next addr", addr, (int'(exp_q[0][10:8]) + 1) % NUM_CH);
                    addr_hold = addr;
                    mux_ch = addr;
                end else if (!rd_n) begin
                    rd_obs++;
                    check("R6 addr stable", addr, addr_hold);
                end else if (!prev_rd) begin
                    check("R3 read length", rd_obs, (rd_len == 3'd0) ? 1 : int'(rd_len));
                    check("R4 valid at read end", m_valid, 1);
                end

                if (m_valid) begin
                    check("R4 valid timing", (!prev_rd && rd_n) ? 1 : 0, 1);
                    if (exp_q.size() == 0) begin
                        check("R4 unexpected beat", 1, 0);
                    end else begin
                        ent = exp_q.pop_front();
                        check("R4 data", m_data, ent[7:0]);
                        check("R5 tag", m_chan, ent[10:8]);
                    end
                    check("R5 tag order", m_chan, tag_seq);
                    tag_seq = (tag_seq + 1) % NUM_CH;
                    n_valid++;
                end

                if (since >= 0) begin
                    if (since == eoc_delay) begin
                        eoc_drv = 1'b0;
                        since = -1;
                    end else begin
                        eoc_drv = 1'b1;
                        since++;
                    end
                end else begin
                    eoc_drv = 1'b1;
                end
                prev_convst = convst_n;
                prev_rd = rd_n;
            end
        end
    end

    task automatic wait_samples(input int n);
        int target;
        target = n_valid + n;
        while (n_valid < target) @(posedge clk);
        #1;
    endtask

    task automatic pause();
        enable = 1'b0;
        repeat (60) @(posedge clk);
        #1;
    endtask

    initial begin : stimulus
        int v0, f0, o0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;

        // R2 R3 R4 R5 R6: steady sampling through a full channel wrap
        period = 8'd30; rd_len = 3'd3; eoc_delay = 8; m_ready = 1'b1;
        enable = 1'b1;
        wait_samples(10);
        check("R8 no overrun at long period", ovr_cnt, 0);

        // R3 zero read length acts as one, R7 beats lost under backpressure
        pause();
        rd_len = 3'd0; period = 8'd24; m_ready = 1'b0;
        enable = 1'b1;
        wait_samples(3);
        m_ready = 1'b1;
        wait_samples(2);
        check("R7 total drops", drop_count, 3);

        // R8 period shorter than one sample's busy time
        pause();
        o0 = ovr_cnt;
        period = 8'd10; rd_len = 3'd1; eoc_delay = 12;
        enable = 1'b1;
        wait_samples(5);
        check("R8 overrun seen", (ovr_cnt > o0) ? 1 : 0, 1);

        // R10 disable right after a start pulse
        pause();
        period = 8'd30; rd_len = 3'd2; eoc_delay = 8;
        f0 = falls;
        enable = 1'b1;
        while (falls == f0) @(posedge clk);
        #1;
        enable = 1'b0;
        v0 = n_valid;
        f0 = falls;
        repeat (100) @(posedge clk);
        #1;
        check("R10 in-flight sample delivered", n_valid, v0 + 1);
        check("R10 no new start", falls, f0);

        summary();
    end

endmodule